// File: doc/BRIEF.md
# Two-Bank GPIO Port Register and Interrupt Logic

This block holds the register state for two banks of eight general-purpose pins and turns it into pin controls. For every pin it keeps a direction bit, an output value, a read-polarity inversion bit, an interrupt mask bit and a pull-resistor select bit. Each bank also has a two-bit keeper/pull enable register. From this state the block drives per-pin output enables, output levels, pull enables and pull directions, plus one bus-hold enable per bank. A serial front end, or any other agent, reaches the registers over a simple synchronous bus. The bus carries a write strobe, a read strobe and a 4-bit register index. Read data is combinational and valid in the cycle the read strobe is high.

The block passes the pin levels through a two-flop synchronizer. It returns them, optionally inverted, as the input port value. Each input pin is compared with a reference value that the block captures whenever that bank's input register is read. An unmasked input pin that differs from its reference sets a status bit. Any set status bit pulls the active-low interrupt enable low. The interrupt goes away when the pin returns to its reference level, or when software reads the input register of the pin's bank.

The register index is `{kind[2:0], bank}`, so the bank number is always the least significant index bit. Kind codes: 0 direction, 1 output, 2 input, 3 inversion, 4 mask, 5 status, 6 keeper/pull enable, 7 pull select.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: A direction bit of 1 makes the pin an input, with `pin_oe_o` low. A direction bit of 0 makes it an output, with `pin_oe_o` high. All direction bits reset to 1.
- R2: Reading the input register (kind 2) returns the synchronized pin levels of that bank XOR the bank's inversion register (kind 3), whatever the pin direction. Writes to the input and status registers change nothing.
- R3: Output registers (kind 1) read back the stored value, not the pin. `pin_out_o` carries the stored bit on output pins and 0 on input pins. Output bits reset to 0.
- R4: Mask bits (kind 4) reset to 1. An interrupt is raised only by a pin whose mask bit is 0, which is configured as input, and whose synchronized level differs from its reference.
- R5: When such a pin returns to its reference level, its status bit clears and the interrupt releases.
- R6: A read of a bank's input register loads that bank's references with the current synchronized levels, which clears its pending status from the next cycle. A read of the other bank's input register leaves the interrupt asserted.
- R7: The status register (kind 5) reads the per-pin interrupt sources. Masked bits read 0. Status reads 0 after reset.
- R8: In the keeper/pull enable register (kind 6), bit 0 = 1 asserts that bank's `hold_en_o` and forces its pull enables low. Bit 1 = 1 with bit 0 = 0 enables the pulls. In that case `pull_up_o` follows the pull select register (kind 7, 1 = up, 0 = down, reset all 1). The enable register resets to 0 and reads back in bits [1:0].
- R9: `irq_no` is 0 while any status bit of either bank is set and 1 otherwise. It is 1 after reset.
- R10: Pin inputs pass through a two-stage synchronizer. A level applied before clock edge k is not yet visible on a read in the cycle that follows edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_idx_i | input | 4 | Register index {kind, bank} |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the indexed register |
| pin_i | input | 16 | Pin levels, bank 1 in bits 15:8 |
| pin_oe_o | output | 16 | Per-pin output driver enable |
| pin_out_o | output | 16 | Per-pin output level |
| hold_en_o | output | 2 | Per-bank bus-hold enable |
| pull_en_o | output | 16 | Per-pin pull resistor enable |
| pull_up_o | output | 16 | Per-pin pull direction, 1 = up |
| irq_no | output | 1 | Interrupt, 0 = drive low, 1 = release |

## Verification
On every cycle the assertions check four things. A direction or output write appears on the pin controls one cycle later. Enabling the keeper disables the pulls. A status bit can appear only after a pin or register change. An input register read leaves no stale source in that bank. Only the bench scenarios can show the rest: inversion and ignored writes on the read path, the two-cycle synchronizer latency, that masked and output pins raise no interrupt, and that the interrupt clears on a same-bank read but not a cross-bank one.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_DIR  = 3'd0,
    K_OUT  = 3'd1,
    K_IN   = 3'd2,
    K_INV  = 3'd3,
    K_MSK  = 3'd4,
    K_STS  = 3'd5,
    K_KEEP = 3'd6,
    K_PSEL = 3'd7
  } reg_kind_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  logic      rd_in_i,   // input register of this bank is being read
  input  reg_kind_e kind_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] sync_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic         hold_o,
  output logic [W-1:0] pull_en_o,
  output logic [W-1:0] pull_up_o,
  output logic [W-1:0] status_o
);
  logic [W-1:0] dir_q, out_q, inv_q, msk_q, psel_q, ref_q;
  logic [1:0]   keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      out_q  <= '0;
      inv_q  <= '0;
      msk_q  <= '1;
      psel_q <= '1;
      keep_q <= '0;
      ref_q  <= '0;
    end else begin
      if (wr_en_i) begin
        unique case (kind_i)
          K_DIR:   dir_q  <= wdata_i;
          K_OUT:   out_q  <= wdata_i;
          K_INV:   inv_q  <= wdata_i;
          K_MSK:   msk_q  <= wdata_i;
          K_KEEP:  keep_q <= wdata_i[1:0];
          K_PSEL:  psel_q <= wdata_i;
          default: ;  // input and status are read-only
        endcase
      end
      if (rd_in_i) ref_q <= sync_i;
    end
  end

  assign status_o  = dir_q & ~msk_q & (sync_i ^ ref_q);
  assign oe_o      = ~dir_q;
  assign out_o     = out_q & ~dir_q;
  assign hold_o    = keep_q[0];
  assign pull_en_o = {W{keep_q[1] & ~keep_q[0]}};
  assign pull_up_o = psel_q;

  always_comb begin
    rdata_o = '0;
    unique case (kind_i)
      K_DIR:  rdata_o = dir_q;
      K_OUT:  rdata_o = out_q;
      K_IN:   rdata_o = sync_i ^ inv_q;
      K_INV:  rdata_o = inv_q;
      K_MSK:  rdata_o = msk_q;
      K_STS:  rdata_o = status_o;
      K_KEEP: rdata_o[1:0] = keep_q;
      K_PSEL: rdata_o = psel_q;
      default: rdata_o = '0;
    endcase
  end

  a_r1_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && kind_i == K_DIR) |=> (oe_o == ~$past(wdata_i)));

  a_r3_out_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && kind_i == K_OUT) |=> ((out_o & oe_o) == ($past(wdata_i) & oe_o)));

  a_r8_keep_overrides_pull: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && kind_i == K_KEEP && wdata_i[0]) |=> (hold_o && pull_en_o == '0));

  a_r5_status_needs_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & ~$past(status_o)) != '0) |-> ((sync_i != $past(sync_i)) || $past(wr_en_i)));

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_in_i |=> ((status_o & ~(sync_i ^ $past(sync_i))) == '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
`timescale 1ns/1ps
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int BANK_W      = 8,
  parameter int NUM_BANKS   = 2,   // must be a power of two, at least 2
  parameter int SYNC_STAGES = 2,
  localparam int PIN_W      = BANK_W * NUM_BANKS,
  localparam int SEL_W      = $clog2(NUM_BANKS),
  localparam int IDX_W      = KIND_W + SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [BANK_W-1:0] reg_wdata_i,
  output logic [BANK_W-1:0] reg_rdata_o,
  input  logic [PIN_W-1:0]  pin_i,
  output logic [PIN_W-1:0]  pin_oe_o,
  output logic [PIN_W-1:0]  pin_out_o,
  output logic [NUM_BANKS-1:0] hold_en_o,
  output logic [PIN_W-1:0]  pull_en_o,
  output logic [PIN_W-1:0]  pull_up_o,
  output logic              irq_no
);
  logic [PIN_W-1:0]  pin_sync, status_all;
  logic [SEL_W-1:0]  bank_sel;
  reg_kind_e         kind;
  logic [BANK_W-1:0] bank_rdata [NUM_BANKS];

  assign bank_sel = reg_idx_i[SEL_W-1:0];
  assign kind     = reg_kind_e'(reg_idx_i[IDX_W-1:SEL_W]);

  gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_sel == SEL_W'(b));

    gpio_bank #(.W(BANK_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (reg_we_i & hit),
      .rd_in_i  (reg_re_i & hit & (kind == K_IN)),
      .kind_i   (kind),
      .wdata_i  (reg_wdata_i),
      .sync_i   (pin_sync[b*BANK_W +: BANK_W]),
      .rdata_o  (bank_rdata[b]),
      .oe_o     (pin_oe_o[b*BANK_W +: BANK_W]),
      .out_o    (pin_out_o[b*BANK_W +: BANK_W]),
      .hold_o   (hold_en_o[b]),
      .pull_en_o(pull_en_o[b*BANK_W +: BANK_W]),
      .pull_up_o(pull_up_o[b*BANK_W +: BANK_W]),
      .status_o (status_all[b*BANK_W +: BANK_W])
    );
  end

  assign reg_rdata_o = bank_rdata[bank_sel];
  assign irq_no      = ~(|status_all);

  // R9: interrupt may only fall after a pin or register change
  a_r9_irq_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> ((pin_sync != $past(pin_sync)) || $past(reg_we_i)));
endmodule

// File: tb/gpio_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [3:0]  idx = '0;
  logic [7:0]  wdata = '0, rdata;
  logic [15:0] pins = '0, oe, pout, pen, pup;
  logic [1:0]  hold;
  logic        irq_n;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;  // 50 MHz

  gpio_bank_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_idx_i(idx), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pin_i(pins), .pin_oe_o(oe), .pin_out_o(pout), .hold_en_o(hold),
    .pull_en_o(pen), .pull_up_o(pup), .irq_no(irq_n)
  );

  // index map {kind, bank}
  localparam logic [3:0] CFG0 = 4'h0, OUT0 = 4'h2, OUT1 = 4'h3, IN0 = 4'h4,
    IN1 = 4'h5, INV1 = 4'h7, MSK0 = 4'h8, MSK1 = 4'h9, STS0 = 4'hA,
    STS1 = 4'hB, KEEP0 = 4'hC, KEEP1 = 4'hD, PSEL0 = 4'hE, PSEL1 = 4'hF;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] i, logic [7:0] d);
    @(posedge clk); #2; we = 1'b1; idx = i; wdata = d;
    @(posedge clk); #2; we = 1'b0;
  endtask

  task automatic rd(logic [3:0] i, logic [7:0] e, string tag);
    @(posedge clk); #2; re = 1'b1; idx = i;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #2; re = 1'b0;
  endtask

  task automatic set_pins(logic [15:0] v);
    @(posedge clk); #2; pins = v;
    repeat (3) @(posedge clk);
    #2;
  endtask

  // monitor: scoreboard compare in the middle of the read cycle
  always @(negedge clk) begin
    if (re) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL unexpected read act=%h exp=none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {8'h00, rdata}, {8'h00, e});
      end
    end
  end

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2; rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1 reset oe", oe, 16'h0000);
    check("R3 reset out", pout, 16'h0000);
    check("R9 reset irq", {15'd0, irq_n}, 16'h0001);
    check("R8 reset hold", {14'd0, hold}, 16'h0000);
    check("R8 reset pull_en", pen, 16'h0000);
    check("R8 reset pull_up", pup, 16'hFFFF);
    rd(CFG0, 8'hFF, "R1 cfg reset");
    rd(OUT1, 8'h00, "R3 out reset");
    rd(MSK0, 8'hFF, "R4 mask reset");
    rd(PSEL1, 8'hFF, "R8 psel reset");
    rd(KEEP0, 8'h00, "R8 keep reset");
    rd(STS0, 8'h00, "R7 status reset");

    // R10 synchronizer latency
    @(posedge clk); #2; pins = 16'h3C5A;
    rd(IN1, 8'h00, "R10 not yet visible");
    repeat (3) @(posedge clk);
    rd(IN1, 8'h3C, "R10 R2 input bank1");
    rd(IN0, 8'h5A, "R2 input bank0");

    // direction and output
    wr(CFG0, 8'h0F);
    wr(OUT0, 8'hA5);
    check("R1 oe after cfg", oe, 16'h00F0);
    check("R3 out gated", pout, 16'h00A0);
    rd(OUT0, 8'hA5, "R3 stored readback");

    // inversion and ignored writes
    wr(INV1, 8'hFF);
    rd(IN1, 8'hC3, "R2 inverted");
    wr(IN0, 8'h77);
    rd(IN0, 8'h5A, "R2 input write ignored");
    wr(STS0, 8'hFF);
    rd(STS0, 8'h00, "R2 status write ignored");

    // interrupt on bank0 bit0
    rd(IN0, 8'h5A, "R6 capture0");
    rd(IN1, 8'hC3, "R6 capture1");
    wr(MSK0, 8'hFE);
    check("R4 no irq before change", {15'd0, irq_n}, 16'h0001);
    set_pins(16'h3C5B);
    check("R4 R9 irq set", {15'd0, irq_n}, 16'h0000);
    rd(STS0, 8'h01, "R7 status source");
    rd(STS1, 8'h00, "R7 other bank clear");
    set_pins(16'h3C5A);
    check("R5 return clears", {15'd0, irq_n}, 16'h0001);
    set_pins(16'h3C5B);
    rd(IN1, 8'hC3, "R6 other bank read");
    check("R6 other bank keeps irq", {15'd0, irq_n}, 16'h0000);
    rd(IN0, 8'h5B, "R6 own bank read");
    check("R6 own read clears", {15'd0, irq_n}, 16'h0001);

    // masked pin and output pin
    set_pins(16'h3C59);
    check("R4 masked no irq", {15'd0, irq_n}, 16'h0001);
    rd(STS0, 8'h00, "R7 masked reads zero");
    wr(MSK0, 8'hEE);
    set_pins(16'h3C49);
    check("R4 output pin no irq", {15'd0, irq_n}, 16'h0001);
    rd(STS0, 8'h00, "R4 output pin status");

    // bank1 source
    wr(MSK1, 8'h7F);
    set_pins(16'hBC49);
    check("R4 bank1 irq", {15'd0, irq_n}, 16'h0000);
    rd(STS1, 8'h80, "R7 bank1 source");
    rd(IN0, 8'h49, "R6 bank0 read");
    check("R6 cross bank keeps", {15'd0, irq_n}, 16'h0000);
    rd(IN1, 8'h43, "R6 bank1 read");
    check("R6 bank1 clears", {15'd0, irq_n}, 16'h0001);

    // keeper / pulls
    wr(KEEP0, 8'h02);
    check("R8 pulls on", pen, 16'h00FF);
    check("R8 hold off", {14'd0, hold}, 16'h0000);
    wr(PSEL0, 8'h0F);
    check("R8 pull dir", pup, 16'hFF0F);
    wr(KEEP0, 8'h03);
    check("R8 hold on", {14'd0, hold}, 16'h0001);
    check("R8 hold overrides pull", pen, 16'h0000);
    rd(KEEP0, 8'h03, "R8 keep readback");
    wr(KEEP1, 8'h00);
    wr(PSEL1, 8'h00);
    check("R8 select ignored when off", pen, 16'h0000);
    check("R8 select stored", pup, 16'h000F);

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard act=%0d exp=0 pending", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule